// File: doc/BRIEF.md
# Pulse-Synchronised Sample Timing Controller

This block drives the conversion timing of a multi-channel transient recorder. A slow reference clock, shared plant-wide and nominally 1 MHz, enters asynchronously and is resampled on the fast system clock. Each rising edge becomes a one-cycle reference tick. Software loads a delay, a decimation factor and a sample count, then arms the block. The block waits for a start-of-pulse trigger. It then counts the programmed number of reference ticks and starts issuing conversion strobes. The base rate is the reference divided by `REF_DIV`, which defaults to 100 and so gives 10 kHz. One strobe line serves all channels, so every converter samples on the same edge.

Lower recording rates come from decimation, not from slowing the converters. The first base-rate sample is kept, then one in every N after it, and the rest are dropped. Each kept sample is handed to a capture buffer. The hand-off is a single-cycle valid pulse together with all channel words and a running index. The index counts up from zero until the programmed number of kept samples has been written, and then the block stops in a finished state.

A free-running divided clock is also produced from the reference, for synchronising switching power converters. A software abort returns the block to idle from any state.

Top module: `sts_timing_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `conv_strobe`, `wr_valid`, `busy`, `done` and `wr_index` are all zero.
- R2: A one-cycle `arm` while idle or finished moves the block to the armed state (`busy`=1) and latches `cfg_delay`, `cfg_keep_n` and `cfg_count`. An `arm` with `cfg_count`=0 is ignored and `busy` stays 0.
- R3: In the armed state, a rising edge on `trig_in` starts a delay of `cfg_delay` reference ticks. The first `conv_strobe` follows the (`cfg_delay`+1)-th rising edge of `ref_in` after the trigger edge.
- R4: While running, `conv_strobe` pulses for one cycle on every `REF_DIV`-th reference tick, and only while running. It is a single line shared by all channels.
- R5: The first strobe of a run is kept, and then every `cfg_keep_n`-th strobe after it. A `cfg_keep_n` of 0 or 1 keeps every strobe, so kept samples are exactly `cfg_keep_n`·`REF_DIV` reference periods apart.
- R6: `wr_valid` pulses in the same cycle as each kept `conv_strobe`. `wr_data` then carries the `adc_data` word presented on the kept tick, unchanged: 16-bit two's-complement, with channel c in bits [16c+15:16c].
- R7: `wr_index` is 0 for the first kept sample of a run and rises by exactly 1 for each later one.
- R8: Once `cfg_count` samples have been kept, the block enters the finished state (`done`=1, `busy`=0) and issues no further strobes.
- R9: A `trig_in` edge while idle, delaying or running has no effect on the number or timing of strobes.
- R10: `abort` sends the block to idle from any state. No `conv_strobe` or `wr_valid` appears in the cycle after it, and a later trigger does nothing until the block is armed again.
- R11: `sync_clk` toggles every `SYNC_HALF` reference ticks in every state, including idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous distributed reference clock |
| trig_in | input | 1 | Asynchronous start-of-pulse trigger |
| arm | input | 1 | One-cycle arm request; latches configuration |
| abort | input | 1 | One-cycle abort to idle |
| cfg_delay | input | DLY_W (32) | Reference ticks from trigger to run |
| cfg_keep_n | input | KW (8) | Decimation factor N (0 behaves as 1) |
| cfg_count | input | CW (16) | Number of kept samples per pulse |
| adc_data | input | NCH*SW (128) | Converter words for all channels |
| conv_strobe | output | 1 | Simultaneous conversion strobe |
| sync_clk | output | 1 | Divided clock for power-converter synchronisation |
| wr_valid | output | 1 | One-cycle capture write strobe |
| wr_index | output | CW (16) | Running index of the kept sample |
| wr_data | output | NCH*SW (128) | Captured channel words |
| busy | output | 1 | Armed, delaying or running |
| done | output | 1 | Programmed count reached |

## Verification
The main function is tried with four setups that differ in delay, decimation factor, count and data pattern. These are zero delay with no decimation, a long delay with N=3, N=0 taken as keep-all, and N=2 over five samples. Together they separate an off-by-one in the delay count, in the first kept strobe or in the stop count from a correct run. Data seeds with the sign bit set and patterns that differ per channel expose a lane swap or a sign mangling in the capture path. Directed runs add trigger edges during the delay and during the run, aborts while armed and while running, a zero count, and a measurement of the converter sync period while idle.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_DELAY = 3'd2,
    ST_RUN   = 3'd3,
    ST_DONE  = 3'd4
  } sts_state_e;
endpackage

// File: rtl/sts_edge_sync.sv
// Multi-flop resynchroniser with rising-edge pulse on the system clock.
module sts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      if (STAGES > 1) sh <= {sh[STAGES-2:0], d};
      else            sh <= d;
      last <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~last;
endmodule

// File: rtl/sts_ref_div.sv
// Base-rate divider (phase restarts on enable) and free-running sync clock.
module sts_ref_div #(
  parameter int REF_DIV   = 100,
  parameter int SYNC_HALF = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  output logic base_tick,
  output logic sync_clk
);
  localparam int DW = $clog2(REF_DIV + 1);
  localparam int HW = $clog2(SYNC_HALF + 1);

  logic [DW-1:0] cnt;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick) cnt <= (cnt == '0) ? DW'(REF_DIV - 1) : cnt - 1'b1;
  end

  assign base_tick = en & tick & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt     <= '0;
      sync_clk <= 1'b0;
    end else if (tick) begin
      if (hcnt == HW'(SYNC_HALF - 1)) begin
        hcnt     <= '0;
        sync_clk <= ~sync_clk;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sts_decim.sv
// Keeps the first tick after clear, then one tick in every keep_n.
module sts_decim #(
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [KW-1:0] keep_n,
  output logic          keep
);
  logic [KW-1:0] kc;
  logic [KW:0]   nxt;

  assign nxt  = {1'b0, kc} + 1'b1;
  assign keep = tick & (kc == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) kc <= '0;
    else if (tick) kc <= (nxt >= {1'b0, keep_n}) ? '0 : nxt[KW-1:0];
  end
endmodule

// File: rtl/sts_timing_ctrl.sv
module sts_timing_ctrl
  import sts_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int SW        = 16,
  parameter int REF_DIV   = 100,
  parameter int SYNC_HALF = 5,
  parameter int DLY_W     = 32,
  parameter int KW        = 8,
  parameter int CW        = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              trig_in,
  input  logic              arm,
  input  logic              abort,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [KW-1:0]     cfg_keep_n,
  input  logic [CW-1:0]     cfg_count,
  input  logic [NCH*SW-1:0] adc_data,
  output logic              conv_strobe,
  output logic              sync_clk,
  output logic              wr_valid,
  output logic [CW-1:0]     wr_index,
  output logic [NCH*SW-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  sts_state_e       state;
  logic             ref_tick, trig_rise, base_tick, keep;
  logic [DLY_W-1:0] dly;
  logic [KW-1:0]    keep_q;
  logic [CW-1:0]    cnt_q, idx;

  sts_edge_sync #(.STAGES(SYNC_STG)) u_ref_sync (
    .clk(clk), .rst(rst), .d(ref_in), .rise(ref_tick));

  sts_edge_sync #(.STAGES(SYNC_STG)) u_trig_sync (
    .clk(clk), .rst(rst), .d(trig_in), .rise(trig_rise));

  sts_ref_div #(.REF_DIV(REF_DIV), .SYNC_HALF(SYNC_HALF)) u_div (
    .clk(clk), .rst(rst), .tick(ref_tick), .en(state == ST_RUN),
    .base_tick(base_tick), .sync_clk(sync_clk));

  sts_decim #(.KW(KW)) u_decim (
    .clk(clk), .rst(rst), .clr(state != ST_RUN), .tick(base_tick),
    .keep_n(keep_q), .keep(keep));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dly         <= '0;
      keep_q      <= '0;
      cnt_q       <= '0;
      idx         <= '0;
      conv_strobe <= 1'b0;
      wr_valid    <= 1'b0;
      wr_index    <= '0;
    end else begin
      conv_strobe <= base_tick & ~abort;
      wr_valid    <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE, ST_DONE: begin
            if (arm && cfg_count != '0) begin
              state  <= ST_ARMED;
              dly    <= cfg_delay;
              keep_q <= cfg_keep_n;
              cnt_q  <= cfg_count;
              idx    <= '0;
            end
          end
          ST_ARMED: if (trig_rise) state <= ST_DELAY;
          ST_DELAY: begin
            if (dly == '0)    state <= ST_RUN;
            else if (ref_tick) dly  <= dly - 1'b1;
          end
          ST_RUN: begin
            if (keep) begin
              wr_valid <= 1'b1;
              wr_index <= idx;
              idx      <= idx + 1'b1;
              if (CW'(idx + 1'b1) == cnt_q) state <= ST_DONE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Per-channel capture registers, written only on a kept tick.
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        wr_data[c*SW +: SW] <= '0;
      else if (state == ST_RUN && keep && !abort)
        wr_data[c*SW +: SW] <= adc_data[c*SW +: SW];
    end
  end

  assign busy = (state == ST_ARMED) || (state == ST_DELAY) || (state == ST_RUN);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/sts_timing_chk.sv
module sts_timing_chk
  import sts_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          abort,
  input logic          conv_strobe,
  input logic          wr_valid,
  input logic [CW-1:0] wr_index,
  input sts_state_e    state
);
  logic          have_prev;
  logic [CW-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst || state == ST_ARMED) begin
      have_prev <= 1'b0;
      last_idx  <= '0;
    end else if (wr_valid) begin
      have_prev <= 1'b1;
      last_idx  <= wr_index;
    end
  end

  assert_valid_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> conv_strobe);

  assert_strobe_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |-> $past(state) == ST_RUN);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state == ST_IDLE && !conv_strobe && !wr_valid));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && $past(state) == ST_DONE) |-> !conv_strobe);

  assert_first_index_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !have_prev) |-> wr_index == '0);

  assert_index_step_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && have_prev) |-> wr_index == CW'(last_idx + 1'b1));
endmodule

bind sts_timing_ctrl sts_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .conv_strobe(conv_strobe),
  .wr_valid(wr_valid), .wr_index(wr_index), .state(state));

// File: tb/sts_timing_ctrl_test.sv
module sts_timing_ctrl_test;
  localparam int NCH = 8, SW = 16, RDIV = 4, SHALF = 3, KW = 4, CW = 8;
  localparam int REFP = 8;          // reference period in clk cycles
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [7:0]  dly;
    logic [3:0]  keep;
    logic [7:0]  cnt;
    logic [15:0] seed;
    logic [7:0]  exp_first;
    logic [7:0]  exp_strobes;
    logic [11:0] exp_gap;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd0, 4'd1, 8'd3, 16'h1234, 8'd1, 8'd3,  12'd32},
    '{8'd5, 4'd3, 8'd4, 16'h8001, 8'd6, 8'd10, 12'd96},
    '{8'd2, 4'd0, 8'd2, 16'hFFFF, 8'd3, 8'd2,  12'd32},
    '{8'd1, 4'd2, 8'd5, 16'h7FFF, 8'd2, 8'd9,  12'd64}
  };

  logic clk = 1'b0, rst = 1'b1, ref_in = 1'b0, trig_in = 1'b0, arm = 1'b0, abort = 1'b0;
  logic [31:0]        cfg_delay = '0;
  logic [KW-1:0]      cfg_keep_n = '0;
  logic [CW-1:0]      cfg_count = '0;
  logic [NCH*SW-1:0]  adc_data = '0, exp_data = '0;
  logic               conv_strobe, sync_clk, wr_valid, busy, done;
  logic [CW-1:0]      wr_index;
  logic [NCH*SW-1:0]  wr_data;

  int checks = 0, fails = 0, cyc = 0;
  int ref_rises = 0, strobes = 0, kept = 0, first_ref = -1;
  int idx_err = 0, data_err = 0, gap_err = 0, last_wr = 0, exp_gap = 0;
  logic ref_q = 1'b0, wd_hit = 1'b0;

  sts_timing_ctrl #(.NCH(NCH), .SW(SW), .REF_DIV(RDIV), .SYNC_HALF(SHALF),
                    .DLY_W(32), .KW(KW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .trig_in(trig_in), .arm(arm),
    .abort(abort), .cfg_delay(cfg_delay), .cfg_keep_n(cfg_keep_n),
    .cfg_count(cfg_count), .adc_data(adc_data), .conv_strobe(conv_strobe),
    .sync_clk(sync_clk), .wr_valid(wr_valid), .wr_index(wr_index),
    .wr_data(wr_data), .busy(busy), .done(done));

  initial forever #5 clk = ~clk;
  initial begin #2; forever #40 ref_in = ~ref_in; end

  function automatic logic [NCH*SW-1:0] make_data(input logic [15:0] seed);
    logic [NCH*SW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*SW +: SW] = seed + 16'(c * 16'h0101);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (ref_in && !ref_q) ref_rises++;
    ref_q = ref_in;
    if (conv_strobe) begin
      strobes++;
      if (strobes == 1) first_ref = ref_rises;
    end
    if (wr_valid) begin
      if (wr_index != CW'(kept)) idx_err++;
      if (wr_data != exp_data) data_err++;
      if (kept > 0 && (cyc - last_wr) != exp_gap) gap_err++;
      last_wr = cyc;
      kept++;
    end
    if (cyc > WATCHDOG && !wd_hit) begin
      wd_hit = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic clear_mon(input int gap);
    strobes = 0; kept = 0; first_ref = -1; idx_err = 0; data_err = 0;
    gap_err = 0; ref_rises = 0; exp_gap = gap;
  endtask

  task automatic do_arm(input int d, input int n, input int c);
    @(negedge clk);
    cfg_delay = 32'(d); cfg_keep_n = KW'(n); cfg_count = CW'(c);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic fire_trig();
    @(posedge ref_in);
    @(negedge clk); @(negedge clk);
    ref_rises = 0;
    trig_in = 1'b1;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    chk(conv_strobe == 0 && wr_valid == 0, "R1 strobes in reset", conv_strobe + wr_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done after reset", busy + done, 0);
    chk(wr_index == 0, "R1 index after reset", wr_index, 0);

    // R11: sync clock half period while idle
    @(posedge sync_clk); @(negedge clk); snap = cyc;
    @(negedge sync_clk); @(negedge clk);
    chk(cyc - snap == SHALF * REFP, "R11 sync half period", cyc - snap, SHALF * REFP);

    // R2: zero count ignored
    do_arm(0, 1, 0);
    @(negedge clk);
    chk(busy == 0, "R2 zero count arm ignored", busy, 0);

    // R9: trigger while idle
    clear_mon(32);
    trig_in = 1'b1; repeat (200) @(negedge clk); trig_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(strobes == 0, "R9 trigger in idle", strobes, 0);

    // Vector table: R2..R8
    for (int v = 0; v < 4; v++) begin
      adc_data = make_data(VECS[v].seed);
      exp_data = adc_data;
      clear_mon(int'(VECS[v].exp_gap));
      do_arm(int'(VECS[v].dly), int'(VECS[v].keep), int'(VECS[v].cnt));
      chk(busy == 1, "R2 armed", busy, 1);
      fire_trig();
      wait_done();
      repeat (3) @(negedge clk);
      chk(first_ref == int'(VECS[v].exp_first), "R3 first strobe ref edge", first_ref, int'(VECS[v].exp_first));
      chk(strobes == int'(VECS[v].exp_strobes), "R5 strobe count", strobes, int'(VECS[v].exp_strobes));
      chk(kept == int'(VECS[v].cnt), "R8 kept count", kept, int'(VECS[v].cnt));
      chk(gap_err == 0, "R4 kept spacing", gap_err, 0);
      chk(idx_err == 0, "R7 index sequence", idx_err, 0);
      chk(data_err == 0, "R6 captured words", data_err, 0);
      chk(done == 1 && busy == 0, "R8 finished flags", {done, busy}, 2);
      snap = strobes;
      repeat (100) @(negedge clk);
      chk(strobes == snap, "R8 quiet after done", strobes, snap);
      trig_in = 1'b0;
    end

    // R9: trigger edges during delay and run
    adc_data = make_data(16'hA5A5); exp_data = adc_data;
    clear_mon(32);
    do_arm(6, 1, 4);
    fire_trig();
    while (ref_rises < 3) @(negedge clk);
    trig_in = 1'b0; repeat (3) @(negedge clk); trig_in = 1'b1;
    while (kept < 2) @(negedge clk);
    trig_in = 1'b0; repeat (3) @(negedge clk); trig_in = 1'b1;
    wait_done();
    repeat (3) @(negedge clk);
    chk(first_ref == 7, "R9 delay unaffected by retrigger", first_ref, 7);
    chk(strobes == 4 && kept == 4, "R9 run unaffected by retrigger", strobes, 4);
    chk(idx_err == 0 && gap_err == 0, "R9 index/spacing after retrigger", idx_err + gap_err, 0);
    trig_in = 1'b0;

    // R10: abort while running
    clear_mon(32);
    do_arm(0, 1, 20);
    fire_trig();
    while (kept < 3) @(negedge clk);
    pulse_abort();
    snap = strobes;
    repeat (200) @(negedge clk);
    chk(strobes == snap, "R10 no strobes after abort", strobes, snap);
    chk(busy == 0 && done == 0, "R10 idle after abort", {busy, done}, 0);
    trig_in = 1'b0;

    // R10: abort while armed, then trigger
    clear_mon(32);
    do_arm(0, 1, 3);
    pulse_abort();
    chk(busy == 0, "R10 abort from armed", busy, 0);
    fire_trig();
    repeat (200) @(negedge clk);
    chk(strobes == 0, "R10 trigger after abort ignored", strobes, 0);
    trig_in = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule